// File: doc/BRIEF.md
# Battery Presence Detection Sequencer

This block decides whether a battery pack is attached to a charger output. It does this in two timed phases, and each phase has its own voltage test. In the first phase a small probe charge current is switched on. If the sensed feedback voltage climbs close to the regulation target, the output is floating, so no pack is attached. If the probe phase runs out its time without that rise, a small discharge load is applied instead. If the feedback voltage then collapses below the low detection level, no pack is attached either. A pack that passes both phases is reported as present.

The analog side supplies two comparator flags and a one-millisecond tick. The block drives the enables for the probe current, the discharge load and a fault trickle load. It reports its verdict with a one-cycle done strobe and two held verdict flags. The probe current is roughly 125 mA for at most 500 ms. The discharge load is roughly 8 mA for at most 1 s. The fault trickle is roughly 2 mA. These magnitudes only describe the analog side. The phase limits are parameters counted in ticks.

While an external safety-timer fault is flagged, the block aborts any sequence and refuses new requests. During that time only the fault trickle load is enabled.

Top module: `bdet_seq`

## Requirements
- R1: After reset every output is 0 and the sequencer is idle.
- R2: A start request seen while idle, with no timer fault, raises the probe-current enable on the next cycle and clears any held verdict at that edge.
- R3: While the probe phase is active, a high near-regulation flag ends the sequence with the absent verdict.
- R4: The probe phase lasts exactly WAKE_MS tick pulses. The edge carrying the last of those pulses moves the sequencer to the discharge phase, and the discharge phase is entered only from the probe phase.
- R5: While the discharge phase is active, a high below-low-level flag ends the sequence with the absent verdict.
- R6: If the discharge phase counts DRAIN_MS tick pulses without a trip, the sequence ends with the present verdict.
- R7: The probe and discharge enables are never high together. The done strobe is high for exactly one cycle per completed sequence, and the sequencer is idle the cycle after it.
- R8: A start request while a sequence is running has no effect: the phase timing continues unchanged.
- R9: A trip and the final timeout tick in the same cycle resolve as a trip, giving the absent verdict.
- R10: While the timer-fault input is high, the fault-load enable is high from the next cycle on. In that time the probe and discharge enables are low, no done strobe occurs, and start requests are ignored.
- R11: The present and absent verdict flags are mutually exclusive and hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| start_req | input | 1 | Request a detection sequence |
| timer_fault | input | 1 | Safety-timer fault flag; aborts and blocks sequencing |
| fb_near_reg | input | 1 | Feedback voltage within the wake window of regulation |
| fb_below_low | input | 1 | Feedback voltage below the discharge detection level |
| wake_chg_en | output | 1 | Probe charge current enable |
| drain_load_en | output | 1 | Discharge load enable |
| fault_load_en | output | 1 | Fault trickle load enable |
| det_done | output | 1 | One-cycle strobe when a verdict is reached |
| bat_present | output | 1 | Held verdict: pack attached |
| bat_absent | output | 1 | Held verdict: no pack |

## Verification
The voltage trip and the expiry of a phase timer can occur in the same cycle, in both the probe phase and the discharge phase. The bench provokes this by ticking every cycle until one tick remains. It then drives the final tick together with the trip flag. The expected result is the absent verdict with done, and no entry into the discharge phase. A behavioural reference model, compared on every clock, also judges start requests issued mid-sequence and a fault raised mid-phase.

// File: rtl/bdet_pkg.sv
package bdet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_RESULT = 2'd3
  } bdet_state_e;
endpackage

// File: rtl/bdet_phase_timer.sv
module bdet_phase_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + CW'(1);
  end

  assign expire = tick && (cnt_q == limit - CW'(1));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/bdet_fsm.sv
module bdet_fsm
  import bdet_pkg::*;
#(
  parameter int WAKE_MS  = 500,
  parameter int DRAIN_MS = 1000,
  parameter int CW       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          timer_fault,
  input  logic          fb_near_reg,
  input  logic          fb_below_low,
  input  logic          expire,
  output bdet_state_e   state,
  output logic          fault_q,
  output logic          clr_timer,
  output logic [CW-1:0] limit,
  output logic          accept,
  output logic          set_present,
  output logic          set_absent
);
  bdet_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    accept      = 1'b0;
    set_present = 1'b0;
    set_absent  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_WAKE;
          accept  = 1'b1;
        end
      end
      ST_WAKE: begin
        if (fb_near_reg) begin
          state_d    = ST_RESULT;
          set_absent = 1'b1;
        end else if (expire) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (fb_below_low) begin
          state_d    = ST_RESULT;
          set_absent = 1'b1;
        end else if (expire) begin
          state_d     = ST_RESULT;
          set_present = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (timer_fault) begin
      state_d     = ST_IDLE;
      accept      = 1'b0;
      set_present = 1'b0;
      set_absent  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= timer_fault;
    end
  end

  assign state     = state_q;
  assign limit     = (state_q == ST_WAKE) ? CW'(WAKE_MS) : CW'(DRAIN_MS);
  assign clr_timer = (state_d != state_q) ||
                     !((state_q == ST_WAKE) || (state_q == ST_DRAIN));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_req && !timer_fault) |=> (state_q == ST_WAKE));
  // R10
  fault_abort_chk: assert property (@(posedge clk) disable iff (rst)
    timer_fault |=> (state_q == ST_IDLE));
  // R7
  result_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESULT) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/bdet_verdict.sv
module bdet_verdict (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic set_present,
  input  logic set_absent,
  output logic present_q,
  output logic absent_q
);
  always_ff @(posedge clk) begin
    if (rst || accept) begin
      present_q <= 1'b0;
      absent_q  <= 1'b0;
    end else if (set_present) begin
      present_q <= 1'b1;
    end else if (set_absent) begin
      absent_q <= 1'b1;
    end
  end

  // R11
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({present_q, absent_q}));
endmodule

// File: rtl/bdet_seq.sv
module bdet_seq
  import bdet_pkg::*;
#(
  parameter int WAKE_MS  = 500,
  parameter int DRAIN_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic start_req,
  input  logic timer_fault,
  input  logic fb_near_reg,
  input  logic fb_below_low,
  output logic wake_chg_en,
  output logic drain_load_en,
  output logic fault_load_en,
  output logic det_done,
  output logic bat_present,
  output logic bat_absent
);
  localparam int MAXL = (WAKE_MS > DRAIN_MS) ? WAKE_MS : DRAIN_MS;
  localparam int CW   = $clog2(MAXL + 1);

  bdet_state_e   state;
  logic          fault_q, clr_timer, expire, accept, set_present, set_absent;
  logic [CW-1:0] limit;

  bdet_fsm #(.WAKE_MS(WAKE_MS), .DRAIN_MS(DRAIN_MS), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req), .timer_fault(timer_fault),
    .fb_near_reg(fb_near_reg), .fb_below_low(fb_below_low), .expire(expire),
    .state(state), .fault_q(fault_q), .clr_timer(clr_timer), .limit(limit),
    .accept(accept), .set_present(set_present), .set_absent(set_absent)
  );

  bdet_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clr(clr_timer), .tick(ms_tick),
    .limit(limit), .expire(expire)
  );

  bdet_verdict u_verdict (
    .clk(clk), .rst(rst), .accept(accept), .set_present(set_present),
    .set_absent(set_absent), .present_q(bat_present), .absent_q(bat_absent)
  );

  assign wake_chg_en   = (state == ST_WAKE);
  assign drain_load_en = (state == ST_DRAIN);
  assign det_done      = (state == ST_RESULT);
  assign fault_load_en = fault_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    det_done |=> !det_done);
  // R4
  drain_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drain_load_en) |-> $past(wake_chg_en));
  // R6
  present_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_present) |-> (det_done && $past(drain_load_en)));
  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault_load_en |-> !(wake_chg_en || drain_load_en || det_done));
endmodule

// File: tb/tb_bdet_seq.sv
module tb_bdet_seq;
  localparam int WAKE  = 500;
  localparam int DRAIN = 1000;

  logic clk = 0, rst = 1;
  logic ms_tick = 0, start_req = 0, timer_fault = 0, fb_near_reg = 0, fb_below_low = 0;
  logic wake_chg_en, drain_load_en, fault_load_en, det_done, bat_present, bat_absent;

  bdet_seq #(.WAKE_MS(WAKE), .DRAIN_MS(DRAIN)) dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit fin = 0;
  int wk_ticks = 0, ds_ticks = 0;
  bit saw_done = 0;

  // reference model: 0 idle, 1 probe, 2 discharge, 3 result
  int m_st = 0, m_cnt = 0;
  bit m_pres = 0, m_abs = 0, m_flt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_pres = 0; m_abs = 0; m_flt = 0;
    end else begin
      m_flt = timer_fault;
      if (timer_fault) begin
        m_st = 0; m_cnt = 0;
      end else begin
        case (m_st)
          0: if (start_req) begin m_st = 1; m_cnt = 0; m_pres = 0; m_abs = 0; end
          1: if (fb_near_reg) begin m_st = 3; m_abs = 1; end
             else if (ms_tick) begin
               m_cnt++;
               if (m_cnt == WAKE) begin m_st = 2; m_cnt = 0; end
             end
          2: if (fb_below_low) begin m_st = 3; m_abs = 1; end
             else if (ms_tick) begin
               m_cnt++;
               if (m_cnt == DRAIN) begin m_st = 3; m_pres = 1; end
             end
          default: m_st = 0;
        endcase
      end
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !fin) begin
      cmp("R4 probe enable", wake_chg_en, m_st == 1);
      cmp("R6 discharge enable", drain_load_en, m_st == 2);
      cmp("R7 done strobe", det_done, m_st == 3);
      cmp("R10 fault load", fault_load_en, m_flt);
      cmp("R6 present verdict", bat_present, m_pres);
      cmp("R3 absent verdict", bat_absent, m_abs);
      cmp("R7 enables exclusive", wake_chg_en && drain_load_en, 1'b0);
    end
  end

  task automatic cyc(logic tk, logic st);
    @(negedge clk);
    ms_tick = tk;
    start_req = st;
    if (wake_chg_en && tk) wk_ticks++;
    if (drain_load_en && tk) ds_ticks++;
    if (det_done) saw_done = 1;
  endtask

  task automatic begin_seq();
    wk_ticks = 0; ds_ticks = 0; saw_done = 0;
    cyc(0, 1);
    cyc(0, 0);
  endtask

  task automatic run_to_done(int budget);
    for (int i = 0; i < budget && !saw_done; i++) cyc(i[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cmp("R1 reset outputs", |{wake_chg_en, drain_load_en, fault_load_en,
                               det_done, bat_present, bat_absent}, 1'b0);

    // R2 / R4 / R6 / R8: full present sequence with a mid-probe restart attempt
    begin_seq();
    cmp("R2 probe on after start", wake_chg_en, 1'b1);
    for (int i = 0; i < 100; i++) cyc(i[0], 0);
    cyc(0, 1); // R8 start while running
    run_to_done(8000);
    cmp("R4 probe tick count", wk_ticks == WAKE, 1'b1);
    cmp("R6 discharge tick count", ds_ticks == DRAIN, 1'b1);
    cmp("R8 restart ignored", wk_ticks + ds_ticks == WAKE + DRAIN, 1'b1);
    cmp("R6 present after full sequence", bat_present, 1'b1);
    cyc(0, 0);
    cmp("R7 idle after done", det_done | wake_chg_en | drain_load_en, 1'b0);

    // R3 probe trip
    begin_seq();
    for (int i = 0; i < 50; i++) cyc(i[0], 0);
    fb_near_reg = 1;
    cyc(0, 0);
    fb_near_reg = 0;
    cmp("R3 absent on probe trip", bat_absent && det_done, 1'b1);
    // R11 verdict held, then cleared on accepted start
    for (int i = 0; i < 20; i++) cyc(1, 0);
    cmp("R11 verdict held", bat_absent, 1'b1);
    begin_seq();
    cmp("R11 verdict cleared on start", bat_absent | bat_present, 1'b0);

    // R5 discharge trip
    while (!drain_load_en) cyc(1, 0);
    for (int i = 0; i < 30; i++) cyc(i[0], 0);
    fb_below_low = 1;
    cyc(0, 0);
    fb_below_low = 0;
    cmp("R5 absent on discharge trip", bat_absent && det_done, 1'b1);
    cyc(0, 0);

    // R9 trip and final probe tick together
    begin_seq();
    while (wk_ticks < WAKE - 1) cyc(1, 0);
    cyc(1, 0);
    fb_near_reg = 1;
    cyc(0, 0);
    fb_near_reg = 0;
    cmp("R9 probe trip beats expiry", bat_absent && det_done && !drain_load_en, 1'b1);
    cyc(0, 0);

    // R9 trip and final discharge tick together
    begin_seq();
    while (!drain_load_en) cyc(1, 0);
    while (ds_ticks < DRAIN - 1) cyc(1, 0);
    cyc(1, 0);
    fb_below_low = 1;
    cyc(0, 0);
    fb_below_low = 0;
    cmp("R9 discharge trip beats expiry", bat_absent && !bat_present, 1'b1);
    cyc(0, 0);

    // R10 fault aborts and blocks
    begin_seq();
    for (int i = 0; i < 40; i++) cyc(i[0], 0);
    timer_fault = 1;
    saw_done = 0;
    cyc(0, 0);
    cmp("R10 fault load on", fault_load_en, 1'b1);
    cmp("R10 probe off in fault", wake_chg_en, 1'b0);
    cyc(0, 1);
    cyc(0, 0);
    cmp("R10 start ignored in fault", wake_chg_en, 1'b0);
    cmp("R10 no done in fault", saw_done, 1'b0);
    timer_fault = 0;
    cyc(0, 0);
    cyc(0, 0);
    cmp("R10 fault load released", fault_load_en, 1'b0);

    // R3 near flag while idle has no effect
    fb_near_reg = 1;
    for (int i = 0; i < 5; i++) cyc(1, 0);
    fb_near_reg = 0;
    cmp("R3 flag ignored when idle", det_done | bat_absent | bat_present, 1'b0);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule